// File: doc/BRIEF.md
# Receiver Gear Switch Event Controller

This block decides when a receiver stops acquiring frequency and starts receiving data. During acquisition the loops run in the fast gear. At a programmable trigger event the controller moves them to the slow gear, which is used for data reception. A 2-bit source code picks the trigger. The choices are a preamble detect pulse, a sync-word detect pulse, or a run of search periods in which the measured frequency error stays small. A small error means its magnitude is below half of an eye threshold. The run length is programmable.

The gear flag is a sticky level. The gain selection for the frequency loop and for the bit-clock loop both follow it. At the event the controller can also freeze the frequency error detector and switch to the narrow channel filter set. Re-entering receive clears the gear flag and the freeze. For a preamble-type source, a sync-word timeout also clears them, because the receiver then returns to preamble search.

Top module: `gear_event_ctrl`

## Requirements
- R1: After reset, `gear_slow`, `det_freeze` and `narrow_filt_sel` are all 0.
- R2: With `cfg_src` = 0, a cycle with `preamble_det` = 1 while in the fast gear sets `gear_slow` to 1 from the next clock edge.
- R3: `cfg_src` = 3 behaves exactly like `cfg_src` = 0 for triggering and for release.
- R4: With `cfg_src` = 1, only `sync_det` triggers the event, and `preamble_det` has no effect. If no sync detect arrives, the block stays in the fast gear indefinitely.
- R5: With `cfg_src` = 2, an `err_valid` strobe counts as small when |`err_value`| (two's complement) is strictly less than `eye_thresh` shifted right by one. The event fires on the strobe that completes N consecutive small strobes, where N = `cfg_consec` and a value of 0 acts as 1.
- R6: A strobe with an error that is not small resets the consecutive count to zero. Cycles without a strobe leave the count unchanged. `rx_enter` also zeroes the count.
- R7: Once set, `gear_slow` stays at 1 until a release (R9, R10). Further triggers have no effect.
- R8: At the event, `det_freeze` becomes 1 only if `cfg_frz_en` is 1 in the event cycle. Changing `cfg_frz_en` afterwards has no effect until the next release.
- R9: A cycle with `rx_enter` = 1 clears `gear_slow` and `det_freeze` at the next edge. This takes priority over a trigger in the same cycle.
- R10: `sync_timeout` = 1 clears `gear_slow` and `det_freeze` when `cfg_src` is 0 or 3. It is ignored when `cfg_src` is 1 or 2.
- R11: `narrow_filt_sel` is 1 exactly when `gear_slow`, `cfg_bw_gear_en` and `cfg_fb_en` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enter | input | 1 | Pulse: receive state (re)entered |
| preamble_det | input | 1 | Pulse: preamble detected |
| sync_det | input | 1 | Pulse: sync word detected |
| sync_timeout | input | 1 | Pulse: sync word search timed out |
| err_valid | input | 1 | Strobe: one search period finished |
| err_value | input | ERR_W | Signed frequency error of that period |
| eye_thresh | input | ERR_W | Unsigned eye threshold |
| cfg_src | input | 2 | Trigger source code |
| cfg_consec | input | CONSEC_W | Consecutive small periods required |
| cfg_frz_en | input | 1 | Freeze detector at the event |
| cfg_bw_gear_en | input | 1 | Bandwidth gearing enable |
| cfg_fb_en | input | 1 | Feedback compensation enable |
| gear_slow | output | 1 | Sticky gear flag (1 = slow gear) |
| det_freeze | output | 1 | Frequency detector freeze |
| narrow_filt_sel | output | 1 | Select narrow channel filter set |

## Verification
The hardest state to reach is the small-error trigger. It needs an exact run of strobed periods whose errors fall just inside the half-threshold bound. Idle cycles and a single large error can be placed inside that run. Directed sequences build such runs. They use errors equal to the bound and one below it, negative values, an interrupting large error and a run length of zero. Long random phases then mix sparse strobes, mostly small errors and rare releases, so that runs complete often and under every source code.

// File: rtl/gear_pkg.sv
package gear_pkg;

   typedef enum logic [1:0] {
      SRC_PREAMBLE     = 2'd0,
      SRC_SYNC         = 2'd1,
      SRC_SMALL_ERR    = 2'd2,
      SRC_PREAMBLE_ALT = 2'd3
   } gear_src_e;

   function automatic logic is_preamble_src(input gear_src_e s);
      return (s == SRC_PREAMBLE) || (s == SRC_PREAMBLE_ALT);
   endfunction

endpackage

// File: rtl/gear_trig_mux.sv
module gear_trig_mux
   import gear_pkg::*;
(
   input  gear_src_e src,
   input  logic      preamble_det,
   input  logic      sync_det,
   input  logic      small_done,
   output logic      trig_evt,
   output logic      pre_src
);

   always_comb begin
      unique case (src)
         SRC_PREAMBLE, SRC_PREAMBLE_ALT: trig_evt = preamble_det;
         SRC_SYNC:                       trig_evt = sync_det;
         SRC_SMALL_ERR:                  trig_evt = small_done;
         default:                        trig_evt = 1'b0;
      endcase
      pre_src = is_preamble_src(src);
   end

endmodule

// File: rtl/gear_small_err_cnt.sv
module gear_small_err_cnt #(
   parameter int ERR_W    = 12,
   parameter int CONSEC_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                err_valid,
   input  logic [ERR_W-1:0]    err_value,
   input  logic [ERR_W-1:0]    eye_thresh,
   input  logic [CONSEC_W-1:0] consec_cfg,
   output logic                small_done
);

   localparam int MAG_W = ERR_W + 1;
   localparam logic [CONSEC_W-1:0] CNT_MAX = {CONSEC_W{1'b1}};
   localparam logic [CONSEC_W-1:0] CNT_ONE = CONSEC_W'(1);

   generate
      if (ERR_W < 2) begin : g_bad_err_w
         $error("gear_small_err_cnt: ERR_W must be at least 2");
      end
      if (CONSEC_W < 1) begin : g_bad_consec_w
         $error("gear_small_err_cnt: CONSEC_W must be at least 1");
      end
   endgenerate

   logic [MAG_W-1:0]    err_ext;
   logic [MAG_W-1:0]    err_mag;
   logic [MAG_W-1:0]    half_eye;
   logic                is_small;
   logic [CONSEC_W-1:0] run_cnt;
   logic [CONSEC_W-1:0] run_inc;
   logic [CONSEC_W-1:0] run_need;

   always_comb begin
      err_ext  = {err_value[ERR_W-1], err_value};
      err_mag  = err_ext[MAG_W-1] ? (~err_ext + MAG_W'(1)) : err_ext;
      half_eye = {2'b00, eye_thresh[ERR_W-1:1]};
      is_small = err_mag < half_eye;
      run_inc  = (run_cnt == CNT_MAX) ? CNT_MAX : run_cnt + CNT_ONE;
      run_need = (consec_cfg == '0) ? CNT_ONE : consec_cfg;
      small_done = err_valid && is_small && (run_inc >= run_need);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         run_cnt <= '0;
      else if (clr)       run_cnt <= '0;
      else if (err_valid) run_cnt <= is_small ? run_inc : '0;
   end

   assert_run_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && !clr && (err_mag >= half_eye)) |=> (run_cnt == '0));

   assert_run_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_valid && !clr) |=> $stable(run_cnt));

   assert_restart_cnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (run_cnt == '0));

endmodule

// File: rtl/gear_event_ctrl.sv
module gear_event_ctrl
   import gear_pkg::*;
#(
   parameter int ERR_W    = 12,
   parameter int CONSEC_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_enter,
   input  logic                preamble_det,
   input  logic                sync_det,
   input  logic                sync_timeout,
   input  logic                err_valid,
   input  logic [ERR_W-1:0]    err_value,
   input  logic [ERR_W-1:0]    eye_thresh,
   input  logic [1:0]          cfg_src,
   input  logic [CONSEC_W-1:0] cfg_consec,
   input  logic                cfg_frz_en,
   input  logic                cfg_bw_gear_en,
   input  logic                cfg_fb_en,
   output logic                gear_slow,
   output logic                det_freeze,
   output logic                narrow_filt_sel
);

   gear_src_e src;
   logic      small_done;
   logic      trig_evt;
   logic      pre_src;
   logic      release_all;

   assign src = gear_src_e'(cfg_src);

   gear_small_err_cnt #(
      .ERR_W    (ERR_W),
      .CONSEC_W (CONSEC_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (rx_enter),
      .err_valid  (err_valid),
      .err_value  (err_value),
      .eye_thresh (eye_thresh),
      .consec_cfg (cfg_consec),
      .small_done (small_done)
   );

   gear_trig_mux u_mux (
      .src          (src),
      .preamble_det (preamble_det),
      .sync_det     (sync_det),
      .small_done   (small_done),
      .trig_evt     (trig_evt),
      .pre_src      (pre_src)
   );

   assign release_all = rx_enter || (sync_timeout && pre_src);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gear_slow  <= 1'b0;
         det_freeze <= 1'b0;
      end else if (release_all) begin
         gear_slow  <= 1'b0;
         det_freeze <= 1'b0;
      end else if (!gear_slow && trig_evt) begin
         gear_slow  <= 1'b1;
         det_freeze <= cfg_frz_en;
      end
   end

   assign narrow_filt_sel = gear_slow && cfg_bw_gear_en && cfg_fb_en;

   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (gear_slow && !rx_enter && !(sync_timeout && pre_src)) |=> gear_slow);

   assert_freeze_needs_gear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      det_freeze |-> gear_slow);

   assert_freeze_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (gear_slow && !release_all) |=> $stable(det_freeze));

   assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_enter |=> (!gear_slow && !det_freeze));

   assert_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gear_slow) |-> $past(trig_evt));

   assert_sync_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_src == 2'd1 && !sync_det) |=> !$rose(gear_slow));

   assert_timeout_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (gear_slow && cfg_src[1:0] inside {2'd1, 2'd2} && !rx_enter) |=> gear_slow);

endmodule

// File: tb/gear_event_ctrl_test.sv
module gear_event_ctrl_test;

   localparam int ERR_W    = 12;
   localparam int CONSEC_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_enter = 0, preamble_det = 0, sync_det = 0, sync_timeout = 0, err_valid = 0;
   logic signed [ERR_W-1:0] err_value = '0;
   logic [ERR_W-1:0] eye_thresh = 12'd200;
   logic [1:0] cfg_src = 2'd0;
   logic [CONSEC_W-1:0] cfg_consec = 3'd3;
   logic cfg_frz_en = 1'b1, cfg_bw_gear_en = 1'b0, cfg_fb_en = 1'b0;
   logic gear_slow, det_freeze, narrow_filt_sel;

   int n_checks = 0;
   int n_fail = 0;
   string tag = "R1";

   bit m_gear = 0, m_frz = 0;
   int m_cnt = 0;

   always #10 clk = ~clk;

   gear_event_ctrl #(.ERR_W(ERR_W), .CONSEC_W(CONSEC_W)) uut (
      .clk(clk), .rst_n(rst_n), .rx_enter(rx_enter), .preamble_det(preamble_det),
      .sync_det(sync_det), .sync_timeout(sync_timeout), .err_valid(err_valid),
      .err_value(err_value), .eye_thresh(eye_thresh), .cfg_src(cfg_src),
      .cfg_consec(cfg_consec), .cfg_frz_en(cfg_frz_en), .cfg_bw_gear_en(cfg_bw_gear_en),
      .cfg_fb_en(cfg_fb_en), .gear_slow(gear_slow), .det_freeze(det_freeze),
      .narrow_filt_sel(narrow_filt_sel));

   function automatic bit err_small(input logic signed [ERR_W-1:0] e, input logic [ERR_W-1:0] t);
      int mag = (e < 0) ? -int'(e) : int'(e);
      return mag < int'(t >> 1);
   endfunction

   task automatic model_step();
      bit pre = (cfg_src == 2'd0) || (cfg_src == 2'd3);
      bit sm = err_small(err_value, eye_thresh);
      int need = (cfg_consec == 0) ? 1 : int'(cfg_consec);
      int inc = (m_cnt + 1 > 7) ? 7 : m_cnt + 1;
      bit done = err_valid && sm && (inc >= need);
      bit trig;
      case (cfg_src)
         2'd1:    trig = sync_det;
         2'd2:    trig = done;
         default: trig = preamble_det;
      endcase
      if (!rst_n) begin
         m_gear = 0; m_frz = 0; m_cnt = 0;
      end else begin
         if (rx_enter || (sync_timeout && pre)) begin
            m_gear = 0; m_frz = 0;
         end else if (!m_gear && trig) begin
            m_gear = 1; m_frz = cfg_frz_en;
         end
         if (rx_enter) m_cnt = 0;
         else if (err_valid) m_cnt = sm ? inc : 0;
      end
   endtask

   task automatic check1(input string what, input bit act, input bit exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      check1("gear_slow", gear_slow, m_gear);
      check1("det_freeze", det_freeze, m_frz);
      check1("narrow_filt_sel (R11)", narrow_filt_sel, m_gear && cfg_bw_gear_en && cfg_fb_en);
      rx_enter = 0; preamble_det = 0; sync_det = 0; sync_timeout = 0; err_valid = 0;
   endtask

   task automatic strobe(input int e);
      err_valid = 1; err_value = ERR_W'(e); tick();
   endtask

   task automatic restart();
      rx_enter = 1; tick();
   endtask

   initial begin
      #3_000_000;
      n_fail++; n_checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      @(negedge clk);
      tag = "R1"; tick(); tick();
      rst_n = 1; tick();

      tag = "R2"; cfg_src = 2'd0; preamble_det = 1; tick();
      tag = "R7"; preamble_det = 1; tick(); tick(); sync_det = 1; tick();
      tag = "R8"; cfg_frz_en = 0; tick();
      tag = "R9"; restart();
      tag = "R8"; cfg_frz_en = 0; preamble_det = 1; tick();
      cfg_frz_en = 1; tick(); tick();
      tag = "R10"; sync_timeout = 1; tick();
      tag = "R3"; cfg_src = 2'd3; preamble_det = 1; tick();
      sync_timeout = 1; tick();

      tag = "R4"; cfg_src = 2'd1;
      for (int i = 0; i < 20; i++) begin preamble_det = 1; tick(); end
      sync_det = 1; tick();
      tag = "R10"; sync_timeout = 1; tick();
      tag = "R11"; cfg_bw_gear_en = 1; tick(); cfg_fb_en = 1; tick();
      cfg_bw_gear_en = 0; tick(); cfg_bw_gear_en = 1;
      tag = "R12_R9"; restart();
      tag = "R9"; cfg_src = 2'd0; rx_enter = 1; preamble_det = 1; tick();

      tag = "R5"; cfg_src = 2'd2; cfg_consec = 3'd3; eye_thresh = 12'd201;
      strobe(100); strobe(-99); tick(); strobe(99);
      restart();
      tag = "R6"; strobe(10); strobe(-10); strobe(-100); strobe(5); strobe(5); strobe(-5);
      restart();
      tag = "R5"; cfg_consec = 3'd0; strobe(-2047); strobe(-2048); strobe(3);
      restart();
      tag = "R6"; cfg_consec = 3'd7;
      for (int i = 0; i < 6; i++) strobe(1);
      rx_enter = 1; err_valid = 1; err_value = 12'd1; tick();
      for (int i = 0; i < 7; i++) strobe(-1);
      tag = "R10"; sync_timeout = 1; tick();

      tag = "random";
      for (int i = 0; i < 6000; i++) begin
         if ($urandom_range(0, 199) == 0) cfg_src = 2'($urandom);
         if ($urandom_range(0, 99) == 0) cfg_consec = 3'($urandom);
         if ($urandom_range(0, 49) == 0) begin
            cfg_frz_en = 1'($urandom); cfg_bw_gear_en = 1'($urandom); cfg_fb_en = 1'($urandom);
         end
         if ($urandom_range(0, 299) == 0) eye_thresh = 12'($urandom_range(0, 600));
         rx_enter     = ($urandom_range(0, 149) == 0);
         preamble_det = ($urandom_range(0, 39) == 0);
         sync_det     = ($urandom_range(0, 39) == 0);
         sync_timeout = ($urandom_range(0, 59) == 0);
         err_valid    = ($urandom_range(0, 3) == 0);
         err_value    = ($urandom_range(0, 9) == 0) ? ERR_W'($urandom)
                                                    : ERR_W'($urandom_range(0, 300) - 150);
         tick();
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule